// File: doc/BRIEF.md
# Lock Elision Controller

This block sits beside a core's load/store path and turns lock operations that carry an elision hint into a speculative region. When a hinted acquire arrives and no region is open, the block drops the lock store and asks the cache tracker to add the lock address to the read set. From then on, any write to that address by another agent ends the region. Any abort reported by the conflict logic also ends it. The matching hinted release then commits the region. It too is kept off the bus, because the lock was never written.

When a region fails, the block reports an abort and raises a retry flag. The core restarts the critical section with that flag set. On the replay, every acquire and release executes as a real atomic operation. The flag drops once a release of the failed lock address has gone through. Only the outermost lock is elided. Inner acquires, hinted or not, pass through as real operations, and a small counter tracks how deep they nest.

Top module: `lock_elide_ctrl`

## Requirements
- R1: After reset, store_suppress_o, rdset_ins_o, commit_o, abort_o and retry_plain_o are all 0.
- R2: With no region open and the retry flag clear, a hinted acquire (op_valid_i=1, op_is_rel_i=0, op_elide_i=1) raises store_suppress_o and rdset_ins_o in the same cycle, with rdset_addr_o equal to op_addr_i. An acquire without the hint raises neither.
- R3: Inside a region, any acquire passes through with store_suppress_o=0 and rdset_ins_o=0.
- R4: Inside a region with no inner lock held, a hinted release whose address equals the elided lock raises store_suppress_o in that cycle. commit_o is then high for exactly one cycle, on the following cycle, and the block returns to idle.
- R5: Inside a region, a remote write (rmt_wr_valid_i=1) whose address equals the elided lock aborts the region. A remote write to any other address has no effect.
- R6: Inside a region, abort_i aborts the region. Outside a region, abort_i has no effect.
- R7: On abort, abort_o is high for one cycle on the cycle after the cause, and retry_plain_o rises in that same cycle. While retry_plain_o is 1, no operation is suppressed and no read-set insert is requested.
- R8: retry_plain_o stays at 1 until a release of the aborted lock address is seen, and it is 0 from the following cycle.
- R9: Inside a region with no inner lock held, a release that lacks the hint, or whose address differs from the elided lock, aborts the region.
- R10: Inner releases pass through without suppression while inner locks are held. An inner acquire made when 2^NEST_W-1 inner locks are already held aborts the region.
- R11: When an abort cause and a committing release arrive in the same cycle, the abort wins: store_suppress_o is 0 in that cycle and commit_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | A lock operation is presented this cycle |
| op_is_rel_i | input | 1 | 1 = release, 0 = acquire |
| op_elide_i | input | 1 | Operation carries the elision hint |
| op_addr_i | input | AW | Lock address of the operation |
| abort_i | input | 1 | Conflict or capacity abort from the cache tracker |
| rmt_wr_valid_i | input | 1 | Another agent writes a lock address |
| rmt_wr_addr_i | input | AW | Address of that remote write |
| store_suppress_o | output | 1 | Drop the lock store of the current operation |
| rdset_ins_o | output | 1 | Insert rdset_addr_o into the read set |
| rdset_addr_o | output | AW | Address to insert |
| commit_o | output | 1 | One-cycle pulse: region committed |
| abort_o | output | 1 | One-cycle pulse: region aborted |
| retry_plain_o | output | 1 | Replay without elision is in progress |

## Verification
Several properties are checked on every cycle. Entering a region suppresses the store and requests an insert. A remote hit on the lock is followed by an abort and the retry flag. A suppressed release is followed by a commit. The retry flag stays up until the matching release. No insert is requested during a replay, and commit and abort never pulse together. Other behaviours show up only in the bench's scenarios: remote writes and aborts being ignored when they do not apply, inner locks passing through at each nesting depth, the nesting overflow, release-address mismatches, and abort winning over a commit in the same cycle.

// File: rtl/lec_pkg.sv
package lec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SPEC   = 2'd1,
    ST_REPLAY = 2'd2
  } lec_state_e;
endpackage

// File: rtl/lec_nest.sv
module lec_nest #(
  parameter int NEST_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic zero_o,
  output logic full_o
);
  localparam logic [NEST_W-1:0] MaxDepth = {NEST_W{1'b1}};

  logic [NEST_W-1:0] depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    depth_q <= '0;
    else if (clr_i) depth_q <= '0;
    else if (inc_i) depth_q <= depth_q + 1'b1;
    else if (dec_i) depth_q <= depth_q - 1'b1;
  end

  assign zero_o = (depth_q == '0);
  assign full_o = (depth_q == MaxDepth);
endmodule

// File: rtl/lec_lock_reg.sv
module lec_lock_reg #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] cmp_a_i,
  input  logic [AW-1:0] cmp_b_i,
  output logic [AW-1:0] lock_o,
  output logic          hit_a_o,
  output logic          hit_b_o
);
  logic [AW-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lock_q <= '0;
    else if (load_i) lock_q <= addr_i;
  end

  assign lock_o  = lock_q;
  assign hit_a_o = (cmp_a_i == lock_q);
  assign hit_b_o = (cmp_b_i == lock_q);
endmodule

// File: rtl/lock_elide_ctrl.sv
module lock_elide_ctrl
  import lec_pkg::*;
#(
  parameter int AW     = 16,
  parameter int NEST_W = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic          op_is_rel_i,
  input  logic          op_elide_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic          abort_i,
  input  logic          rmt_wr_valid_i,
  input  logic [AW-1:0] rmt_wr_addr_i,
  output logic          store_suppress_o,
  output logic          rdset_ins_o,
  output logic [AW-1:0] rdset_addr_o,
  output logic          commit_o,
  output logic          abort_o,
  output logic          retry_plain_o
);
  lec_state_e    state_q, state_d;
  logic          acq, rel, in_spec, in_replay;
  logic          start, fail, fin, replay_done;
  logic          op_hit, rmt_hit, nest_zero, nest_full;
  logic          commit_q, abort_q;
  logic [AW-1:0] lock_addr;

  assign acq       = op_valid_i & ~op_is_rel_i;
  assign rel       = op_valid_i & op_is_rel_i;
  assign in_spec   = (state_q == ST_SPEC);
  assign in_replay = (state_q == ST_REPLAY);

  lec_lock_reg #(.AW(AW)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start),
    .addr_i  (op_addr_i),
    .cmp_a_i (op_addr_i),
    .cmp_b_i (rmt_wr_addr_i),
    .lock_o  (lock_addr),
    .hit_a_o (op_hit),
    .hit_b_o (rmt_hit)
  );

  lec_nest #(.NEST_W(NEST_W)) u_nest (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .inc_i  (in_spec & ~fail & acq),
    .dec_i  (in_spec & ~fail & rel & ~nest_zero),
    .zero_o (nest_zero),
    .full_o (nest_full)
  );

  // only the outermost lock is elided
  assign start = (state_q == ST_IDLE) & acq & op_elide_i;

  // abort causes outrank a committing release
  assign fail = in_spec & (abort_i
                         | (rmt_wr_valid_i & rmt_hit)
                         | (acq & nest_full)
                         | (rel & nest_zero & ~(op_elide_i & op_hit)));

  assign fin         = in_spec & ~fail & rel & nest_zero;
  assign replay_done = in_replay & rel & op_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start)       state_d = ST_SPEC;
      ST_SPEC:   if (fail)        state_d = ST_REPLAY;
                 else if (fin)    state_d = ST_IDLE;
      ST_REPLAY: if (replay_done) state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      commit_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      commit_q <= fin;
      abort_q  <= fail;
    end
  end

  assign store_suppress_o = start | fin;
  assign rdset_ins_o      = start;
  assign rdset_addr_o     = op_addr_i;
  assign commit_o         = commit_q;
  assign abort_o          = abort_q;
  assign retry_plain_o    = in_replay;
endmodule

// File: rtl/lec_checker.sv
module lec_checker #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          op_valid_i,
  input logic          op_is_rel_i,
  input logic          op_elide_i,
  input logic [AW-1:0] op_addr_i,
  input logic          rmt_wr_valid_i,
  input logic [AW-1:0] rmt_wr_addr_i,
  input logic          store_suppress_o,
  input logic          rdset_ins_o,
  input logic          commit_o,
  input logic          abort_o,
  input logic          retry_plain_o,
  input logic [1:0]    state_q,
  input logic [AW-1:0] lock_addr
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !commit_o && !abort_o && !retry_plain_o);

  a_r2_enter_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == 2'd0 && op_valid_i && !op_is_rel_i && op_elide_i)
      |-> store_suppress_o && rdset_ins_o);

  a_r4_commit_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == 2'd1 && store_suppress_o) |=> commit_o && !retry_plain_o);

  a_r5_remote_hit_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == 2'd1 && rmt_wr_valid_i && rmt_wr_addr_i == lock_addr)
      |=> abort_o && retry_plain_o);

  a_r7_no_insert_in_replay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_plain_o |-> !rdset_ins_o && !store_suppress_o);

  a_r8_retry_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_plain_o && !(op_valid_i && op_is_rel_i && op_addr_i == lock_addr))
      |=> retry_plain_o);

  a_r11_exclusive_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && abort_o));
endmodule

bind lock_elide_ctrl lec_checker #(.AW(AW)) u_lec_checker (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .op_valid_i       (op_valid_i),
  .op_is_rel_i      (op_is_rel_i),
  .op_elide_i       (op_elide_i),
  .op_addr_i        (op_addr_i),
  .rmt_wr_valid_i   (rmt_wr_valid_i),
  .rmt_wr_addr_i    (rmt_wr_addr_i),
  .store_suppress_o (store_suppress_o),
  .rdset_ins_o      (rdset_ins_o),
  .commit_o         (commit_o),
  .abort_o          (abort_o),
  .retry_plain_o    (retry_plain_o),
  .state_q          (state_q),
  .lock_addr        (lock_addr)
);

// File: tb/lock_elide_ctrl_bench.sv
module lock_elide_ctrl_bench;
  localparam int AW = 16;
  localparam int NEST_W = 2;
  localparam int MAXN = (1 << NEST_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_v = 0, op_rel = 0, op_el = 0, ab = 0, rw_v = 0;
  logic [AW-1:0] op_a = '0, rw_a = '0;
  logic sup, ins, cmt, abo, rty;
  logic [AW-1:0] ins_a;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  int m_state = 0;   // 0 idle, 1 region, 2 replay
  int m_lock  = 0;
  int m_nest  = 0;
  bit m_cmt = 0, m_abo = 0;

  always #5 clk = ~clk;

  lock_elide_ctrl #(.AW(AW), .NEST_W(NEST_W)) u_lock_elide_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .op_valid_i(op_v), .op_is_rel_i(op_rel), .op_elide_i(op_el), .op_addr_i(op_a),
    .abort_i(ab), .rmt_wr_valid_i(rw_v), .rmt_wr_addr_i(rw_a),
    .store_suppress_o(sup), .rdset_ins_o(ins), .rdset_addr_o(ins_a),
    .commit_o(cmt), .abort_o(abo), .retry_plain_o(rty)
  );

  task automatic step(input bit v, input bit r, input bit e, input int a,
                      input bit abt, input bit wv, input int wa, input string tag);
    bit e_sup, e_ins, fail, fin, acq, rl;
    @(negedge clk);
    op_v = v; op_rel = r; op_el = e; op_a = AW'(a);
    ab = abt; rw_v = wv; rw_a = AW'(wa);
    #1;
    acq = v && !r; rl = v && r;
    e_sup = 0; e_ins = 0; fail = 0; fin = 0;
    if (m_state == 0 && acq && e) begin
      e_sup = 1; e_ins = 1;
    end else if (m_state == 1) begin
      fail = abt || (wv && wa == m_lock) || (acq && m_nest == MAXN) ||
             (rl && m_nest == 0 && !(e && a == m_lock));
      fin  = !fail && rl && m_nest == 0;
      e_sup = fin;
    end
    checks++;
    if (sup !== e_sup || ins !== e_ins || (e_ins && ins_a !== AW'(a)) ||
        cmt !== m_cmt || abo !== m_abo || rty !== (m_state == 2)) begin
      failures++;
      $display("FAIL %s: sup=%0b/%0b ins=%0b/%0b cmt=%0b/%0b abo=%0b/%0b rty=%0b/%0b",
               tag, sup, e_sup, ins, e_ins, cmt, m_cmt, abo, m_abo, rty, (m_state == 2));
    end
    m_cmt = fin; m_abo = fail;
    case (m_state)
      0: if (acq && e) begin m_state = 1; m_lock = a; m_nest = 0; end
      1: if (fail) m_state = 2;
         else if (fin) m_state = 0;
         else if (acq) m_nest++;
         else if (rl) m_nest--;
      2: if (rl && a == m_lock) m_state = 0;
      default: ;
    endcase
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    checks++;
    if (sup !== 0 || ins !== 0 || cmt !== 0 || abo !== 0 || rty !== 0) begin
      failures++;
      $display("FAIL R1: outputs %0b%0b%0b%0b%0b expected 00000", sup, ins, cmt, abo, rty);
    end
    rst_n = 1'b1;
    idle("R1");
    // plain acquire in idle is not elided
    step(1, 0, 0, 'h40, 0, 0, 0, "R2 untagged");
    step(1, 1, 0, 'h40, 0, 0, 0, "R2 untagged rel");
    // R6 abort ignored in idle
    step(0, 0, 0, 0, 1, 0, 0, "R6 idle abort");
    idle("R6");
    // elide, inner locks, commit
    step(1, 0, 1, 'h40, 0, 0, 0, "R2 enter");
    step(1, 0, 1, 'h80, 0, 0, 0, "R3 inner tagged");
    step(1, 0, 0, 'h84, 0, 0, 0, "R3 inner plain");
    step(1, 1, 0, 'h84, 0, 0, 0, "R10 inner rel");
    step(1, 1, 1, 'h80, 0, 0, 0, "R10 inner rel");
    step(0, 0, 0, 0, 0, 1, 'h99, "R5 other addr");
    step(1, 1, 1, 'h40, 0, 0, 0, "R4 commit rel");
    idle("R4 pulse");
    idle("R4 done");
    // remote hit
    step(1, 0, 1, 'h40, 0, 0, 0, "R2 enter");
    step(0, 0, 0, 0, 0, 1, 'h40, "R5 hit");
    idle("R7 pulse");
    step(1, 0, 1, 'h40, 0, 0, 0, "R7 real acquire");
    step(0, 0, 0, 0, 1, 0, 0, "R6 abort in replay");
    step(1, 1, 1, 'h44, 0, 0, 0, "R8 other rel");
    step(1, 1, 1, 'h40, 0, 0, 0, "R8 match rel");
    idle("R8 cleared");
    // abort_i
    step(1, 0, 1, 'h22, 0, 0, 0, "R2 enter");
    step(0, 0, 0, 0, 1, 0, 0, "R6 abort");
    idle("R7");
    step(1, 1, 0, 'h22, 0, 0, 0, "R8 untagged rel");
    idle("R8");
    // mismatched release
    step(1, 0, 1, 'h30, 0, 0, 0, "R2 enter");
    step(1, 1, 1, 'h31, 0, 0, 0, "R9 wrong addr");
    idle("R9");
    step(1, 1, 0, 'h30, 0, 0, 0, "R8");
    // untagged release of the lock
    step(1, 0, 1, 'h30, 0, 0, 0, "R2 enter");
    step(1, 1, 0, 'h30, 0, 0, 0, "R9 no hint");
    step(1, 1, 0, 'h30, 0, 0, 0, "R8");
    idle("R8");
    // nest overflow
    step(1, 0, 1, 'h10, 0, 0, 0, "R2 enter");
    for (int i = 0; i < MAXN; i++) step(1, 0, 1, 'h100 + i, 0, 0, 0, "R10 fill");
    step(1, 0, 1, 'h200, 0, 0, 0, "R10 overflow");
    idle("R10");
    step(1, 1, 1, 'h10, 0, 0, 0, "R8");
    // abort wins over commit
    step(1, 0, 1, 'h50, 0, 0, 0, "R2 enter");
    step(1, 1, 1, 'h50, 1, 0, 0, "R11 race");
    idle("R11");
    step(1, 1, 1, 'h50, 0, 0, 0, "R8");
    step(1, 0, 1, 'h50, 0, 0, 0, "R2 enter");
    step(1, 1, 1, 'h50, 0, 1, 'h50, "R11 remote race");
    idle("R11");
    idle("R7");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule